// File: doc/BRIEF.md
# Display Panel Power Sequencer

This block switches the supplies and signals of a flat-panel display module on and off in a fixed order. A power request turns on, one stage at a time, the digital logic rail, then the analog rail together with the negative gate rail, then the positive gate rail, then the video and logic signal drivers, and last the backlight. Dropping the request switches the same stages off in reverse order. An active-low panel reset is held while the logic rail comes up and is released only after a minimum hold.

All delays are counted in pulses of an external tick strobe, so the timing scales with whatever time base the system supplies. Each of the first three rails can report power-good. A stage that waits too long for its rail to report power-good raises a fault and triggers the power-off sequence. Once the logic rail is off, a long off-time has to pass before another power-up can begin.

Top module: `panel_pwr_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, every enable, `panel_rst_n_o` and `fault_o` are low. The block then starts in the off-time wait.
- R2: Enables form a thermometer code in the order logic, analog/negative gate, positive gate, signals, backlight. A stage is never on unless every earlier stage is on, so signals are never driven while the logic rail is off. No more than one enable changes in any cycle.
- R3: With power-good present, each enable during power-up rises exactly T+1 ticks after the previous one, where T is the minimum for that step. The minimums are `T_DIG_MIN`, `T_ANA_MIN`, `T_GATE_MIN` and `T_SIG_MIN`.
- R4: The block waits for a late power-good signal inside the maximum window and advances one tick after both conditions hold. If power-good arrives k ticks after the logic enable rises, with k+1 at least `T_DIG_MIN`, the analog enable rises k+2 ticks after the logic enable.
- R5: The block sets `fault_o` if a stage's power-good is still low `T_*_MAX` ticks after that stage's enable rises. One tick later that stage switches off, and the remaining stages then shut down as in R6.
- R6: When the request drops, the highest stage that is on turns off first. Each lower stage follows `T_DN_GAP`+1 ticks after the one above it, whether power-up had finished or not.
- R7: `panel_rst_n_o` rises `T_RST` ticks after the logic enable rises and falls in the same cycle as the logic enable falls. It is never high while the logic enable is low.
- R8: A new power-up starts only after the off-time. The logic enable can rise again no earlier than `T_OFF_MIN`+2 ticks after it fell. After reset, it rises no earlier than `T_OFF_MIN`+3 cycles after reset is released. A request made during the off-time has no effect until the off-time ends.
- R9: `fault_o` stays high, and no power-up begins, until the request is seen low in the idle state. The fault then clears one cycle later, and a new request starts a normal power-up.
- R10: Timers advance only on cycles where `tick_i` is high. Cycles without a tick lengthen the current step by exactly that many cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_req_i | input | 1 | High requests the panel powered, low requests it off |
| tick_i | input | 1 | Time-base strobe, one count per high cycle |
| pg_i | input | 3 | Power-good for logic, analog/negative gate and positive gate rails (bit 0 = logic) |
| dig_en_o | output | 1 | Logic rail enable |
| ana_en_o | output | 1 | Analog and negative gate rail enable |
| gate_en_o | output | 1 | Positive gate rail enable |
| sig_en_o | output | 1 | Video and logic signal driver enable |
| bl_en_o | output | 1 | Backlight enable |
| panel_rst_n_o | output | 1 | Active-low panel reset |
| fault_o | output | 1 | Power-good timeout flag |

## Verification
A wrong stage count shows up at the enable outputs on the next cycle, as a gap in the thermometer code or as two enables changing together. A step timer that is off shows up as an edge-to-edge gap that differs from T+1 on the very next transition. An early release of the off-time or of the fault lock shows up as a logic enable rising too soon after the previous shutdown. The bench records the cycle of every output edge and compares the gaps with values derived from the delay parameters.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int NUM_STAGES = 5;  // logic, analog/neg gate, pos gate, signals, backlight
  localparam int NUM_PG     = 3;  // rails that report power-good
  localparam int SW         = $clog2(NUM_STAGES + 1);

  typedef enum logic [1:0] {
    PS_HOLD,  // off-time wait
    PS_IDLE,  // waiting for a request
    PS_UP,    // powering up or fully on
    PS_DOWN   // shutting down in reverse order
  } pps_state_e;
endpackage

// File: rtl/pps_step_timer.sv
module pps_step_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      count <= '0;
    else if (tick && (count != {CW{1'b1}}))
      count <= count + 1'b1;
  end
endmodule

// File: rtl/pps_rail_reg.sv
module pps_rail_reg
  import pps_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [SW-1:0]         stage,
  output logic [NUM_STAGES-1:0] rail_q
);
  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_rail
    always_ff @(posedge clk) begin
      if (rst)
        rail_q[i] <= 1'b0;
      else
        rail_q[i] <= (stage > SW'(i));
    end
  end
endmodule

// File: rtl/pps_rst_gen.sv
module pps_rst_gen #(
  parameter int RST_TICKS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic dig_on,
  input  logic tick,
  output logic rst_n_q
);
  localparam int RW = $clog2(RST_TICKS + 2);
  localparam logic [RW-1:0] LIM = RW'(RST_TICKS);

  logic [RW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !dig_on) begin
      cnt     <= '0;
      rst_n_q <= 1'b0;
    end else begin
      if (tick && (cnt < LIM))
        cnt <= cnt + 1'b1;
      rst_n_q <= (cnt >= LIM);
    end
  end
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import pps_pkg::*;
#(
  parameter int          T_DIG_MIN  = 1,
  parameter int          T_DIG_MAX  = 1000,
  parameter int          T_ANA_MIN  = 1,
  parameter int          T_ANA_MAX  = 1000,
  parameter int          T_GATE_MIN = 1000,
  parameter int          T_GATE_MAX = 1000,
  parameter int          T_SIG_MIN  = 2000,
  parameter int          T_DN_GAP   = 1000,
  parameter int          T_OFF_MIN  = 20000,
  parameter int          T_RST      = 5,
  parameter logic [2:0]  PG_USED    = 3'b111
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_req_i,
  input  logic       tick_i,
  input  logic [2:0] pg_i,
  output logic       dig_en_o,
  output logic       ana_en_o,
  output logic       gate_en_o,
  output logic       sig_en_o,
  output logic       bl_en_o,
  output logic       panel_rst_n_o,
  output logic       fault_o
);
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int TMAX = imax(imax(imax(T_DIG_MIN, T_DIG_MAX), imax(T_ANA_MIN, T_ANA_MAX)),
                             imax(imax(T_GATE_MIN, T_GATE_MAX),
                                  imax(T_SIG_MIN, imax(T_DN_GAP, T_OFF_MIN))));
  localparam int CW = $clog2(TMAX + 2);

  pps_state_e           st_q, st_n;
  logic [SW-1:0]        stg_q, stg_n;
  logic                 fault_q, fault_n;
  logic                 clr;
  logic [CW-1:0]        cnt;
  logic [CW-1:0]        cur_min, cur_max;
  logic                 cur_pg_ok, has_pg;
  logic [NUM_PG-1:0]    pg_ok;
  logic [NUM_STAGES-1:0] rails;

  assign pg_ok = pg_i | ~PG_USED;

  always_comb begin
    cur_min   = CW'(T_SIG_MIN);
    cur_max   = '1;
    cur_pg_ok = 1'b1;
    has_pg    = 1'b0;
    case (stg_q)
      SW'(1): begin cur_min = CW'(T_DIG_MIN);  cur_max = CW'(T_DIG_MAX);  cur_pg_ok = pg_ok[0]; has_pg = 1'b1; end
      SW'(2): begin cur_min = CW'(T_ANA_MIN);  cur_max = CW'(T_ANA_MAX);  cur_pg_ok = pg_ok[1]; has_pg = 1'b1; end
      SW'(3): begin cur_min = CW'(T_GATE_MIN); cur_max = CW'(T_GATE_MAX); cur_pg_ok = pg_ok[2]; has_pg = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    st_n    = st_q;
    stg_n   = stg_q;
    fault_n = fault_q;
    clr     = 1'b0;
    case (st_q)
      PS_HOLD: begin
        if (cnt >= CW'(T_OFF_MIN)) begin
          st_n = PS_IDLE;
          clr  = 1'b1;
        end
      end
      PS_IDLE: begin
        if (!pwr_req_i)
          fault_n = 1'b0;
        else if (!fault_q) begin
          st_n  = PS_UP;
          stg_n = SW'(1);
          clr   = 1'b1;
        end
      end
      PS_UP: begin
        if (!pwr_req_i || (has_pg && !cur_pg_ok && (cnt >= cur_max))) begin
          if (pwr_req_i)
            fault_n = 1'b1;
          stg_n = stg_q - 1'b1;
          st_n  = (stg_q == SW'(1)) ? PS_HOLD : PS_DOWN;
          clr   = 1'b1;
        end else if ((stg_q < SW'(NUM_STAGES)) && cur_pg_ok && (cnt >= cur_min)) begin
          stg_n = stg_q + 1'b1;
          clr   = 1'b1;
        end
      end
      PS_DOWN: begin
        if (cnt >= CW'(T_DN_GAP)) begin
          stg_n = stg_q - 1'b1;
          st_n  = (stg_q == SW'(1)) ? PS_HOLD : PS_DOWN;
          clr   = 1'b1;
        end
      end
      default: st_n = PS_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= PS_HOLD;
      stg_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      stg_q   <= stg_n;
      fault_q <= fault_n;
    end
  end

  pps_step_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .tick  (tick_i),
    .count (cnt)
  );

  pps_rail_reg u_rails (
    .clk    (clk),
    .rst    (rst),
    .stage  (stg_q),
    .rail_q (rails)
  );

  pps_rst_gen #(.RST_TICKS(T_RST)) u_rstgen (
    .clk     (clk),
    .rst     (rst),
    .dig_on  (stg_q != '0),
    .tick    (tick_i),
    .rst_n_q (panel_rst_n_o)
  );

  assign dig_en_o  = rails[0];
  assign ana_en_o  = rails[1];
  assign gate_en_o = rails[2];
  assign sig_en_o  = rails[3];
  assign bl_en_o   = rails[4];
  assign fault_o   = fault_q;
endmodule

// File: rtl/pps_chk.sv
module pps_chk (
  input logic       clk,
  input logic       rst,
  input logic [4:0] rails,
  input logic       rst_n,
  input logic       fault
);
  // R2: enables always form a thermometer code starting at the logic rail
  a_r2_rail_order: assert property (@(posedge clk) disable iff (rst)
    ((({1'b0, rails} + 6'd1) & {1'b0, rails}) == 6'd0));

  // R2: one enable changes per cycle at most
  a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
    ($countones(rails ^ $past(rails)) <= 1));

  // R7: panel reset held whenever the logic rail is off
  a_r7_reset_needs_dig: assert property (@(posedge clk) disable iff (rst)
    (!rails[0] |-> !rst_n));

  // R5: a new fault is followed by a stage switching off
  a_r5_fault_sheds: assert property (@(posedge clk) disable iff (rst)
    ($rose(fault) |=> (rails < $past(rails))));

  // R9: no enable rises while the fault stays latched
  a_r9_no_rise_in_fault: assert property (@(posedge clk) disable iff (rst)
    ((fault && $past(fault)) |-> ((rails & ~$past(rails)) == 5'd0)));

  // R9: power-up never starts with the fault set
  a_r9_start_clean: assert property (@(posedge clk) disable iff (rst)
    ($rose(rails[0]) |-> !fault));
endmodule

bind panel_pwr_seq pps_chk u_pps_chk (
  .clk   (clk),
  .rst   (rst),
  .rails ({bl_en_o, sig_en_o, gate_en_o, ana_en_o, dig_en_o}),
  .rst_n (panel_rst_n_o),
  .fault (fault_o)
);

// File: tb/tb_panel_pwr_seq.sv
module tb_panel_pwr_seq;
  localparam int DMIN = 3, DMAX = 8, AMIN = 2, AMAX = 8, GMIN = 5, GMAX = 8;
  localparam int SMIN = 7, DN = 2, OFF = 20, RSTT = 4;
  localparam int WATCHDOG = 20000;

  // phase, from index, to index, expected gap, requirement number
  // phase 0 uses rise times, phase 1 uses fall times
  // index: 0 logic, 1 analog, 2 pos gate, 3 signals, 4 backlight, 5 panel reset, 6 fault
  localparam int NV = 10;
  localparam int GAPS [NV][5] = '{
    '{0, 0, 1, DMIN + 1, 3},  // R3
    '{0, 1, 2, AMIN + 1, 3},  // R3
    '{0, 2, 3, GMIN + 1, 3},  // R3
    '{0, 3, 4, SMIN + 1, 3},  // R3
    '{0, 0, 5, RSTT,     7},  // R7
    '{1, 4, 3, DN + 1,   6},  // R6
    '{1, 3, 2, DN + 1,   6},  // R6
    '{1, 2, 1, DN + 1,   6},  // R6
    '{1, 1, 0, DN + 1,   6},  // R6
    '{1, 0, 5, 0,        7}   // R7
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic tick = 1'b1;
  logic [2:0] pg = 3'b111;
  logic dig, ana, gate, sig, bl, prst_n, flt;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int rise_t [7];
  int fall_t [7];
  logic [6:0] prev = '0;
  logic [6:0] mon;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  panel_pwr_seq #(
    .T_DIG_MIN(DMIN), .T_DIG_MAX(DMAX), .T_ANA_MIN(AMIN), .T_ANA_MAX(AMAX),
    .T_GATE_MIN(GMIN), .T_GATE_MAX(GMAX), .T_SIG_MIN(SMIN), .T_DN_GAP(DN),
    .T_OFF_MIN(OFF), .T_RST(RSTT), .PG_USED(3'b111)
  ) dut (
    .clk(clk), .rst(rst), .pwr_req_i(req), .tick_i(tick), .pg_i(pg),
    .dig_en_o(dig), .ana_en_o(ana), .gate_en_o(gate), .sig_en_o(sig),
    .bl_en_o(bl), .panel_rst_n_o(prst_n), .fault_o(flt)
  );

  assign mon = {flt, prst_n, bl, sig, gate, ana, dig};

  always @(negedge clk) begin
    for (int i = 0; i < 7; i++) begin
      if (mon[i] && !prev[i]) rise_t[i] = cyc;
      if (!mon[i] && prev[i]) fall_t[i] = cyc;
    end
    prev = mon;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_val(input int idx, input logic v, input int limit, input string tag);
    int n = 0;
    while (mon[idx] !== v && n < limit) begin
      step();
      n++;
    end
    check(tag, int'(mon[idx]), int'(v));
  endtask

  task automatic run_phase(input int p);
    for (int k = 0; k < NV; k++) begin
      if (GAPS[k][0] == p) begin
        int act;
        act = (p == 0) ? rise_t[GAPS[k][2]] - rise_t[GAPS[k][1]]
                       : fall_t[GAPS[k][2]] - fall_t[GAPS[k][1]];
        check($sformatf("R%0d gap %0d->%0d", GAPS[k][4], GAPS[k][1], GAPS[k][2]), act, GAPS[k][3]);
      end
    end
  endtask

  initial begin
    wait (cyc >= WATCHDOG);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int rel;
    repeat (4) step();
    // R1: reset state
    check("R1 outputs in reset", int'(mon), 0);
    rel = cyc;
    rst = 1'b0;
    req = 1'b1;
    step();
    check("R1 outputs after release", int'(mon), 0);

    // full power-up
    wait_val(4, 1'b1, 200, "R3 backlight on");
    check("R8 first start after reset", rise_t[0] - rel, OFF + 3);
    run_phase(0);

    // R6: full power-down
    req = 1'b0;
    wait_val(0, 1'b0, 200, "R6 logic off");
    run_phase(1);

    // R8: request during off-time
    req = 1'b1;
    repeat (OFF / 2) step();
    check("R8 request ignored in off-time", int'(dig), 0);
    wait_val(0, 1'b1, 200, "R8 logic on again");
    check("R8 off-time gap", rise_t[0] - fall_t[0], OFF + 2);

    // R6: abort in mid power-up
    wait_val(1, 1'b1, 200, "R6 analog on");
    req = 1'b0;
    wait_val(0, 1'b0, 200, "R6 abort logic off");
    check("R6 abort gate never on", int'(gate), 0);
    check("R6 abort gap", fall_t[0] - fall_t[1], DN + 1);

    // R4: late power-good
    pg = 3'b110;
    req = 1'b1;
    wait_val(0, 1'b1, 200, "R4 logic on");
    repeat (5) step();
    pg = 3'b111;
    wait_val(1, 1'b1, 200, "R4 analog on");
    check("R4 late power-good gap", rise_t[1] - rise_t[0], 5 + 2);

    // R5: positive gate power-good missing
    pg = 3'b011;
    wait_val(6, 1'b1, 200, "R5 fault raised");
    check("R5 fault timing", rise_t[6] - rise_t[2], GMAX);
    wait_val(0, 1'b0, 200, "R5 logic off");
    check("R5 gate off after fault", fall_t[2] - rise_t[6], 1);
    check("R5 signals never on", rise_t[3] < rise_t[2] ? 1 : 0, 1);
    check("R5 reverse gap", fall_t[1] - fall_t[2], DN + 1);

    // R9: fault lock
    repeat (OFF + 20) step();
    check("R9 no restart while faulted", int'(dig), 0);
    check("R9 fault still set", int'(flt), 1);
    req = 1'b0;
    pg = 3'b111;
    step();
    step();
    check("R9 fault cleared", int'(flt), 0);
    req = 1'b1;
    wait_val(0, 1'b1, 50, "R9 restart after clear");

    // R10: missing ticks stretch the step
    wait_val(3, 1'b1, 200, "R10 signals on");
    tick = 1'b0;
    repeat (10) step();
    tick = 1'b1;
    wait_val(4, 1'b1, 200, "R10 backlight on");
    check("R10 stretched gap", rise_t[4] - rise_t[3], SMIN + 11);

    req = 1'b0;
    wait_val(0, 1'b0, 200, "R6 final off");
    check("R7 reset low after off", int'(prst_n), 0);

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule